// File: doc/BRIEF.md
# Hot-plug interrupt locator aggregator

This block gathers the interrupt sources of a hot-plug slot controller into one 32-bit locator word and one interrupt request. Each slot has a 5-bit latch of pending events and a disable byte. A slot is pending when any of its latched events is not disabled. The command path adds one more source, a command-completion flag that has its own disable bit. The register file that holds these values sits outside this block and feeds them in as plain inputs. The aggregator works out a new result on every clock, so every register write and every newly latched event shows up on the next cycle.

The locator gives bit 0 to command completion and gives slot `i` the bit `i+1`. A request level follows from the locator and a global disable. The level can drive the pin-based interrupt. When message-signalled interrupts are turned on, the level instead produces a one-cycle message request on each low-to-high change. That change is measured against a tracked copy of the last level. A restore strobe clears the tracked copy, and so does reset, so that a condition still pending at that point signals again.

Top module: `hp_irq_locator`

## Requirements
- R1: Locator bit `i+1` is 1 exactly when `evt_latch_i[5i+4:5i] & ~evt_dis_i[8i+4:8i]` is nonzero. Event bit codes: presence 0x01, isolated fault 0x02, button 0x04, retention latch 0x08, connected fault 0x10. `locator_o` shows this one clock after the inputs.
- R2: Locator bit 0 is 1 exactly when `cmd_done_i` is 1 and `cmd_irq_dis_i` is 0, with the same one-cycle latency.
- R3: Disable-byte bits 7:5 have no effect. Locator bits above `NUM_SLOTS` are always 0.
- R4: `level_o` is 1 exactly when `irq_dis_i` was 0 and the locator computed from the same inputs is nonzero. It is aligned with `locator_o`.
- R5: `intx_o` equals `level_o` while `msi_en_i` was 0, and is 0 while it was 1.
- R6: `msi_o` pulses for exactly one cycle when message interrupts are enabled, the new level is 1 and the tracked level is 0.
- R7: A level that stays high produces no further `msi_o` pulse.
- R8: `restore_i` clears the tracked level and suppresses `msi_o` in that cycle. A level still high afterwards then pulses `msi_o` on the next cycle.
- R9: After reset all outputs are 0 and the tracked level is 0.
- R10: The tracked level follows the level even while message interrupts are disabled. Enabling them while the level is already high gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_latch_i | input | 5*NUM_SLOTS | Per-slot latched events, slot i at bits 5i+4:5i |
| evt_dis_i | input | 8*NUM_SLOTS | Per-slot disable byte, slot i at bits 8i+7:8i |
| cmd_done_i | input | 1 | Command-completion detected flag |
| cmd_irq_dis_i | input | 1 | Disables the command-completion source |
| irq_dis_i | input | 1 | Global interrupt disable |
| msi_en_i | input | 1 | Message-signalled interrupts enabled |
| restore_i | input | 1 | State-restore strobe, clears the tracked level |
| locator_o | output | 32 | Registered interrupt locator word |
| level_o | output | 1 | Registered aggregated request level |
| intx_o | output | 1 | Pin-based interrupt |
| msi_o | output | 1 | One-cycle message request |

## Verification
Some properties are checked on every cycle. A message pulse never lasts two cycles and always comes with a high level. The pin and the message outputs are never active together. A high level always comes with a nonzero locator. Locator bits above the last slot stay zero. Other behaviour only the bench scenarios can show: the exact bit each slot's unmasked events set, that disable-byte bits 7:5 have no effect, that tracking goes on while message interrupts are off, and that a restore makes a pending condition signal again one cycle later.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
  localparam int EVT_W  = 5;
  localparam int DIS_W  = 8;
  localparam int LOC_W  = 32;
  localparam int CMD_BIT = 0;

  localparam logic [EVT_W-1:0] EV_PRESENCE  = 5'h01;
  localparam logic [EVT_W-1:0] EV_ISO_FAULT = 5'h02;
  localparam logic [EVT_W-1:0] EV_BUTTON    = 5'h04;
  localparam logic [EVT_W-1:0] EV_LATCH     = 5'h08;
  localparam logic [EVT_W-1:0] EV_CON_FAULT = 5'h10;
endpackage

// File: rtl/hp_slot_hit.sv
module hp_slot_hit
  import hp_irq_pkg::*;
(
  input  logic [EVT_W-1:0] latch_i,
  input  logic [DIS_W-1:0] dis_i,
  output logic             hit_o
);
  // only the low disable bits pair with event bits
  assign hit_o = |(latch_i & ~dis_i[EVT_W-1:0]);
endmodule

// File: rtl/hp_loc_build.sv
module hp_loc_build
  import hp_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS*EVT_W-1:0] evt_latch_i,
  input  logic [NUM_SLOTS*DIS_W-1:0] evt_dis_i,
  input  logic                       cmd_done_i,
  input  logic                       cmd_irq_dis_i,
  output logic [LOC_W-1:0]           loc_o
);
  localparam int UNUSED_W = LOC_W - 1 - NUM_SLOTS;

  logic [NUM_SLOTS-1:0] hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hp_slot_hit u_hit (
      .latch_i (evt_latch_i[s*EVT_W +: EVT_W]),
      .dis_i   (evt_dis_i[s*DIS_W +: DIS_W]),
      .hit_o   (hit[s])
    );
  end

  if (UNUSED_W > 0) begin : g_pad
    assign loc_o = {{UNUSED_W{1'b0}}, hit, cmd_done_i & ~cmd_irq_dis_i};
  end else begin : g_full
    assign loc_o = {hit, cmd_done_i & ~cmd_irq_dis_i};
  end
endmodule

// File: rtl/hp_irq_signal.sv
module hp_irq_signal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic irq_dis_i,
  input  logic msi_en_i,
  input  logic restore_i,
  output logic level_o,
  output logic intx_o,
  output logic msi_o
);
  logic level_d;
  logic trk_q, level_q, intx_q, msi_q;

  assign level_d = pend_i & ~irq_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q   <= 1'b0;
      level_q <= 1'b0;
      intx_q  <= 1'b0;
      msi_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      intx_q  <= level_d & ~msi_en_i;
      // restore forgets the last requested level
      msi_q   <= msi_en_i & level_d & ~trk_q & ~restore_i;
      trk_q   <= restore_i ? 1'b0 : level_d;
    end
  end

  assign level_o = level_q;
  assign intx_o  = intx_q;
  assign msi_o   = msi_q;
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
  import hp_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SLOTS*EVT_W-1:0] evt_latch_i,
  input  logic [NUM_SLOTS*DIS_W-1:0] evt_dis_i,
  input  logic                       cmd_done_i,
  input  logic                       cmd_irq_dis_i,
  input  logic                       irq_dis_i,
  input  logic                       msi_en_i,
  input  logic                       restore_i,
  output logic [LOC_W-1:0]           locator_o,
  output logic                       level_o,
  output logic                       intx_o,
  output logic                       msi_o
);
  logic [LOC_W-1:0] loc_d, loc_q;

  hp_loc_build #(.NUM_SLOTS(NUM_SLOTS)) u_build (
    .evt_latch_i   (evt_latch_i),
    .evt_dis_i     (evt_dis_i),
    .cmd_done_i    (cmd_done_i),
    .cmd_irq_dis_i (cmd_irq_dis_i),
    .loc_o         (loc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loc_q <= '0;
    else         loc_q <= loc_d;
  end

  hp_irq_signal u_sig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (|loc_d),
    .irq_dis_i (irq_dis_i),
    .msi_en_i  (msi_en_i),
    .restore_i (restore_i),
    .level_o   (level_o),
    .intx_o    (intx_o),
    .msi_o     (msi_o)
  );

  assign locator_o = loc_q;
endmodule

// File: rtl/hp_irq_locator_chk.sv
module hp_irq_locator_chk
  import hp_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LOC_W-1:0] locator_o,
  input logic             level_o,
  input logic             intx_o,
  input logic             msi_o
);
  // R7
  msi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |=> !msi_o);

  // R6
  msi_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |-> level_o);

  // R5
  intx_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intx_o |-> level_o);

  // R5
  intx_msi_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(intx_o && msi_o));

  // R4
  level_loc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o |-> (locator_o != '0));

  // R3
  loc_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locator_o >> (NUM_SLOTS + 1)) == '0);
endmodule

bind hp_irq_locator hp_irq_locator_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .locator_o (locator_o),
  .level_o   (level_o),
  .intx_o    (intx_o),
  .msi_o     (msi_o)
);

// File: tb/sim_hp_irq_locator.sv
module sim_hp_irq_locator;
  localparam int CLK_P = 10;
  localparam int NS    = 4;

  typedef struct {
    int          due;
    string       tag;
    logic [31:0] loc;
    logic        lvl;
    logic        intx;
    logic        msi;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS*5-1:0] latch = '0;
  logic [NS*8-1:0] dis = '0;
  logic            cmd_done = 1'b0, cmd_dis = 1'b0, irq_dis = 1'b0;
  logic            msi_en = 1'b0, restore = 1'b0;
  logic [31:0]     locator;
  logic            level, intx, msi;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic trk = 1'b0;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hp_irq_locator #(.NUM_SLOTS(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_latch_i(latch), .evt_dis_i(dis),
    .cmd_done_i(cmd_done), .cmd_irq_dis_i(cmd_dis), .irq_dis_i(irq_dis),
    .msi_en_i(msi_en), .restore_i(restore), .locator_o(locator),
    .level_o(level), .intx_o(intx), .msi_o(msi)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: inputs already set, called just after a negedge
  task automatic step(string tag);
    exp_t e;
    logic [31:0] l = '0;
    logic lv;
    for (int s = 0; s < NS; s++)
      l[s+1] = |(latch[s*5 +: 5] & ~dis[s*8 +: 5]);
    l[0] = cmd_done & ~cmd_dis;
    lv = ~irq_dis & (l != 0);
    e.due = cyc + 1; e.tag = tag; e.loc = l; e.lvl = lv;
    e.intx = lv & ~msi_en;
    e.msi = msi_en & lv & ~trk & ~restore;
    trk = restore ? 1'b0 : lv;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "locator", locator, e.loc);
      check(e.tag, "level", {31'b0, level}, {31'b0, e.lvl});
      check(e.tag, "intx", {31'b0, intx}, {31'b0, e.intx});
      check(e.tag, "msi", {31'b0, msi}, {31'b0, e.msi});
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "locator", locator, 32'h0);
    check("R9", "outs", {29'b0, level, intx, msi}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R9 idle");
    // R2 command source
    cmd_done = 1'b1; step("R2 cmd");
    cmd_dis = 1'b1;  step("R2 cmd disabled");
    cmd_done = 1'b0; cmd_dis = 1'b0;
    // R1 slot events, unmasked and masked
    latch[0*5 +: 5] = 5'h01; step("R1 slot0 presence");
    latch[2*5 +: 5] = 5'h04; step("R1 slot2 button");
    dis[0*8 +: 8] = 8'h01;  step("R1 slot0 masked");
    latch[3*5 +: 5] = 5'h18; dis[3*8 +: 8] = 8'h08; step("R1 slot3 partial mask");
    // R3 upper disable bits ignored
    latch = '0; dis = '0;
    latch[1*5 +: 5] = 5'h02; dis[1*8 +: 8] = 8'hE0; step("R3 upper dis bits");
    dis[1*8 +: 8] = 8'hFF; step("R3 full mask");
    // R4 global disable
    latch[1*5 +: 5] = 5'h10; dis = '0; irq_dis = 1'b1; step("R4 global dis");
    irq_dis = 1'b0; step("R4 enabled");
    // R10 tracked follows with msi off, then enable: no pulse
    msi_en = 1'b1; step("R10 enable while high");
    // R7 stays high
    step("R7 hold");
    // R6 fall then rise
    latch = '0; step("R6 low");
    latch[0*5 +: 5] = 5'h08; step("R6 rise");
    step("R7 hold again");
    // R8 restore re-signals
    restore = 1'b1; step("R8 restore");
    restore = 1'b0; step("R8 resignal");
    step("R8 after");
    // R5 back to pin mode
    msi_en = 1'b0; step("R5 pin");
    latch = '0; cmd_done = 1'b1; step("R5 pin cmd");
    step("R5 drain");
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule